// File: doc/BRIEF.md
# Split-Bus to Shared-Line Peripheral Bridge

This block lets a host with separate address and data buses and a single I/O strobe talk to a byte-wide peripheral that uses one set of lines for both address and data. Such a peripheral expects an address latch enable, a read strobe, a write strobe and a chip select. The host has none of these. It has an I/O-space select, one active-low strobe and a read/write direction line that holds its level for the whole cycle.

The bridge uses the lowest host address bit to pick the kind of access. An access to an odd host address is an address phase. The low data byte goes onto the shared lines and the latch enable pulses for as long as the strobe is low. An access to an even host address is a data phase. The read or write strobe follows the host strobe, and the direction line decides which of the two it is.

Software therefore writes the register number to the odd port, then reads or writes the register contents at the even port. The bridge also decides which way the shared-line drivers point. The chip select is decoded from the I/O-space select and the top host address bits.

Top module: `mxb_bridge`

## Requirements
- R1: `p_cs_n` is 0 exactly when `h_iosel_n` is 0 and `h_addr[15:14]` equals the parameter `DEC_MATCH` (default 2'b11). Otherwise it is 1.
- R2: Address phase. With chip select active, `h_addr[0]`=1 and `h_strb_n`=0, `p_ale` is 1 and both `p_rd_n` and `p_wr_n` are 1. This holds for either level of `h_rw`.
- R3: Data phase. With chip select active, `h_addr[0]`=0 and `h_strb_n`=0, `p_ale` is 0. `p_rd_n` is 0 when `h_rw`=1, and `p_wr_n` is 0 when `h_rw`=0. `p_rd_n` and `p_wr_n` are never 0 at the same time.
- R4: While `p_cs_n` is 1, `p_ale` is 0 and `p_rd_n` and `p_wr_n` are 1, whatever the values of `h_addr[0]`, `h_strb_n` and `h_rw`.
- R5: While `h_strb_n` is 1, `p_ale` is 0 and `p_rd_n` and `p_wr_n` are 1.
- R6: `p_ad_out` always carries `h_wdata`. `p_ad_oe` is 1 whenever `p_ale` is 1.
- R7: Data-phase read. With chip select active, `h_addr[0]`=0 and `h_rw`=1, `p_ad_oe` is 0 and `h_rdata_oe` is 1. `h_rdata` carries `p_ad_in`. `p_ad_oe` and `h_rdata_oe` are never 1 at the same time.
- R8: In every other combination, `h_rdata_oe` is 0 and `p_ad_oe` equals the active level of chip select.
- R9: A peripheral that captures the shared lines on the falling edge of `p_ale` receives the byte written to the odd port. A following data write stores the even-port byte at that register. A later address write and data read of the same register return that byte on `h_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock, used for property sampling |
| rst_n | input | 1 | Active-low reset, disables the properties |
| h_addr | input | 16 | Host address; bit 0 selects the phase, the top bits feed the decode |
| h_wdata | input | 8 | Host write data (low byte of the host data bus) |
| h_rdata | output | 8 | Read data returned to the host |
| h_rdata_oe | output | 1 | Drive enable toward the host data bus |
| h_iosel_n | input | 1 | Host I/O-space select, active low |
| h_strb_n | input | 1 | Host I/O strobe, active low |
| h_rw | input | 1 | Host direction: 1 read, 0 write |
| p_ad_out | output | 8 | Byte driven onto the shared lines |
| p_ad_oe | output | 1 | Drive enable toward the shared lines |
| p_ad_in | input | 8 | Byte returned by the peripheral on the shared lines |
| p_ale | output | 1 | Address latch enable, active high |
| p_rd_n | output | 1 | Peripheral read strobe, active low |
| p_wr_n | output | 1 | Peripheral write strobe, active low |
| p_cs_n | output | 1 | Peripheral chip select, active low |

## Verification
All bridge outputs follow the host lines with no register in the path. A wrong phase decision therefore shows on `p_ale`, `p_rd_n` or `p_wr_n` during the same strobe. It shows up as a stray latch pulse or as a read and a write strobe at once. A wrong direction choice shows in the same cycle as both drive enables high, or as neither high during a read. Errors that only change what the peripheral stores surface later. They appear when the bench reads the register back and finds the wrong byte or the byte meant for another register.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_RD   = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  // Classify one host access from its live control levels.
  function automatic phase_e classify(input logic cs, input logic strb_n,
                                      input logic a0, input logic rw);
    phase_e p;
    if (!cs || strb_n) p = PH_IDLE;
    else if (a0)       p = PH_ADDR;
    else if (rw)       p = PH_RD;
    else               p = PH_WR;
    return p;
  endfunction

  // True when the peripheral is the one driving data back to the host.
  function automatic logic is_return_path(input logic cs, input logic a0,
                                          input logic rw);
    return cs && !a0 && rw;
  endfunction

endpackage

// File: rtl/mxb_decode.sv
module mxb_decode #(
  parameter int ADDR_W    = 16,
  parameter int DEC_W     = 2,
  parameter logic [DEC_W-1:0] DEC_MATCH = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iosel_n,
  output logic              cs
);
  localparam int TOP = ADDR_W - 1;

  logic [DEC_W-1:0] hi_bits;
  logic             hi_hit;

  assign hi_bits = addr[TOP -: DEC_W];
  assign hi_hit  = (hi_bits == DEC_MATCH);
  assign cs      = hi_hit && !iosel_n;

  // R1: no select while the I/O space is not addressed
  assert_cs_needs_io_R1: assert property (@(posedge clk) disable iff (!rst_n)
    iosel_n |-> !cs);

endmodule

// File: rtl/mxb_phase.sv
module mxb_phase
  import mxb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs,
  input  logic   strb_n,
  input  logic   a0,
  input  logic   rw,
  output phase_e phase,
  output logic   ale,
  output logic   rd_n,
  output logic   wr_n
);

  assign phase = classify(cs, strb_n, a0, rw);

  always_comb begin
    ale  = 1'b0;
    rd_n = 1'b1;
    wr_n = 1'b1;
    case (phase)
      PH_ADDR: ale  = 1'b1;
      PH_RD:   rd_n = 1'b0;
      PH_WR:   wr_n = 1'b0;
      default: ;
    endcase
  end

  assert_ale_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  assert_rdwr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_csoff_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!ale && rd_n && wr_n));

  assert_strobe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb_n |-> (!ale && rd_n && wr_n));

endmodule

// File: rtl/mxb_steer.sv
module mxb_steer
  import mxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              a0,
  input  logic              rw,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [DATA_W-1:0] p_ad_in,
  output logic [DATA_W-1:0] p_ad_out,
  output logic              p_ad_oe,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_rdata_oe
);
  logic ret_path;

  assign ret_path   = is_return_path(cs, a0, rw);
  assign p_ad_out   = h_wdata;
  assign p_ad_oe    = cs && !ret_path;
  assign h_rdata    = p_ad_in;
  assign h_rdata_oe = ret_path;

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_ad_oe && h_rdata_oe));

  assert_idle_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!p_ad_oe && !h_rdata_oe));

endmodule

// File: rtl/mxb_bridge.sv
module mxb_bridge
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEC_W  = 2,
  parameter logic [DEC_W-1:0] DEC_MATCH = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_rdata_oe,
  input  logic              h_iosel_n,
  input  logic              h_strb_n,
  input  logic              h_rw,
  output logic [DATA_W-1:0] p_ad_out,
  output logic              p_ad_oe,
  input  logic [DATA_W-1:0] p_ad_in,
  output logic              p_ale,
  output logic              p_rd_n,
  output logic              p_wr_n,
  output logic              p_cs_n
);
  logic   cs_hit;
  logic   phase_sel;
  phase_e phase;

  assign phase_sel = h_addr[0];
  assign p_cs_n    = !cs_hit;

  mxb_decode #(
    .ADDR_W(ADDR_W), .DEC_W(DEC_W), .DEC_MATCH(DEC_MATCH)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(h_addr), .iosel_n(h_iosel_n), .cs(cs_hit)
  );

  mxb_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cs(cs_hit), .strb_n(h_strb_n),
    .a0(phase_sel), .rw(h_rw), .phase(phase),
    .ale(p_ale), .rd_n(p_rd_n), .wr_n(p_wr_n)
  );

  mxb_steer #(.DATA_W(DATA_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .cs(cs_hit), .a0(phase_sel), .rw(h_rw),
    .h_wdata(h_wdata), .p_ad_in(p_ad_in), .p_ad_out(p_ad_out),
    .p_ad_oe(p_ad_oe), .h_rdata(h_rdata), .h_rdata_oe(h_rdata_oe)
  );

  // R6: address bytes are only latched while the bridge drives the lines
  assert_ale_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    p_ale |-> p_ad_oe);

  // R7: a read strobe always has the return path open
  assert_rd_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !p_rd_n |-> h_rdata_oe);

  // R3: a write strobe never coincides with the return path
  assert_wr_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !p_wr_n |-> (p_ad_oe && phase == PH_WR));

endmodule

// File: tb/mxb_bridge_tb.sv
module mxb_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        h_rdata_oe;
  logic        h_iosel_n = 1'b1;
  logic        h_strb_n = 1'b1;
  logic        h_rw = 1'b1;
  logic [7:0]  p_ad_out;
  logic        p_ad_oe;
  logic [7:0]  p_ad_in;
  logic        p_ale, p_rd_n, p_wr_n, p_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mxb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rdata_oe(h_rdata_oe), .h_iosel_n(h_iosel_n),
    .h_strb_n(h_strb_n), .h_rw(h_rw), .p_ad_out(p_ad_out), .p_ad_oe(p_ad_oe),
    .p_ad_in(p_ad_in), .p_ale(p_ale), .p_rd_n(p_rd_n), .p_wr_n(p_wr_n),
    .p_cs_n(p_cs_n)
  );

  // Peripheral model: address captured as the latch enable falls.
  logic [7:0] pmem [256];
  logic [7:0] preg_sel = '0;
  always @(negedge p_ale) if (!p_cs_n) preg_sel = p_ad_out;
  always @(posedge p_wr_n) if (!p_cs_n) pmem[preg_sel] = p_ad_out;
  assign p_ad_in = (!p_rd_n && !p_cs_n) ? pmem[preg_sel] : 8'h00;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One three-cycle host I/O access; returns the sampled read byte.
  task automatic host_io(input logic [15:0] a, input logic rw,
                         input logic [7:0] d, output logic [7:0] rd);
    @(posedge clk);
    h_iosel_n = 1'b0; h_addr = a; h_rw = rw; h_wdata = d;
    @(negedge clk);
    h_strb_n = 1'b0;
    @(posedge clk); #1;
    rd = h_rdata;
    @(negedge clk);
    h_strb_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    h_iosel_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rb;
    for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
    #1;
    // Idle state after power-up: R4 and R5
    check(p_ale == 0 && p_rd_n && p_wr_n && p_cs_n && !p_ad_oe && !h_rdata_oe,
          "R4 idle", {p_ale, p_rd_n, p_wr_n, p_cs_n, p_ad_oe, h_rdata_oe}, 6'b011100);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Exhaustive sweep of select, top bits, phase bit, direction, strobe.
    for (int v = 0; v < 64; v++) begin
      logic iosel, a0, rw, st;
      logic [1:0] hi;
      logic e_cs, e_ale, e_rd, e_wr, e_ret, e_oe;
      @(negedge clk);
      iosel = v[0]; hi = v[2:1]; a0 = v[3]; rw = v[4]; st = v[5];
      h_iosel_n = iosel; h_addr = {hi, 13'h0A5, a0}; h_rw = rw; h_strb_n = st;
      h_wdata = 8'(v * 37 + 11);
      #1;
      e_cs  = !iosel && (hi == 2'b11);
      e_ale = e_cs && !st && a0;
      e_rd  = e_cs && !st && !a0 && rw;
      e_wr  = e_cs && !st && !a0 && !rw;
      e_ret = e_cs && !a0 && rw;
      e_oe  = e_cs && !e_ret;
      check(p_cs_n == !e_cs, "R1 chip select", p_cs_n, !e_cs);
      if (!e_cs)
        check(!p_ale && p_rd_n && p_wr_n, "R4 quiet without select",
              {p_ale, p_rd_n, p_wr_n}, 3'b011);
      else if (st)
        check(!p_ale && p_rd_n && p_wr_n, "R5 quiet without strobe",
              {p_ale, p_rd_n, p_wr_n}, 3'b011);
      else if (a0)
        check(p_ale && p_rd_n && p_wr_n, "R2 address phase",
              {p_ale, p_rd_n, p_wr_n}, 3'b111);
      else
        check(!p_ale && p_rd_n == !e_rd && p_wr_n == !e_wr, "R3 data phase",
              {p_ale, p_rd_n, p_wr_n}, {1'b0, !e_rd, !e_wr});
      if (e_ret)
        check(h_rdata_oe && !p_ad_oe && h_rdata == p_ad_in, "R7 return path",
              {h_rdata_oe, p_ad_oe, h_rdata}, {2'b10, p_ad_in});
      else
        check(!h_rdata_oe && p_ad_oe == e_oe, "R8 forward direction",
              {h_rdata_oe, p_ad_oe}, {1'b0, e_oe});
      check(p_ad_out == h_wdata, "R6 byte passthrough", p_ad_out, h_wdata);
      @(negedge clk);
      h_strb_n = 1'b1; h_iosel_n = 1'b1;
    end

    // Register sequence: address write, data write, address write, data read.
    for (int r = 0; r < 16; r++) begin
      logic [7:0] reg_id, val;
      reg_id = 8'(r * 17 + 3);
      val    = 8'(r * 29 + 101);
      host_io(16'hC001, 1'b0, reg_id, rb);
      check(preg_sel == reg_id, "R9 address latched", preg_sel, reg_id);
      host_io(16'hC000, 1'b0, val, rb);
      check(pmem[reg_id] == val, "R9 data stored", pmem[reg_id], val);
    end
    for (int r = 0; r < 16; r++) begin
      logic [7:0] reg_id, val;
      reg_id = 8'(r * 17 + 3);
      val    = 8'(r * 29 + 101);
      host_io(16'hC001, 1'b0, reg_id, rb);
      host_io(16'hC000, 1'b1, 8'hEE, rb);
      check(rb == val, "R9 readback", rb, val);
    end

    // Deselected access must not disturb the peripheral (R4).
    host_io(16'h4001, 1'b0, 8'h77, rb);
    check(preg_sel == 8'(15 * 17 + 3), "R4 no latch when deselected",
          preg_sel, 8'(15 * 17 + 3));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule